// File: doc/BRIEF.md
# Bus Error and Timeout Generator

This block sits in the interconnect of a single-master, Wishbone-style shared bus. It guarantees that every bus cycle ends. A cycle ends with an acknowledge from the addressed slave, or it ends with an error at the master. The block checks the master's cycle, strobe and address against a fixed address map. It routes the strobe to exactly one slave select line, and it returns that slave's acknowledge or error to the master.

The interconnect raises the error itself in two cases:
- the address lies in an unmapped region, or
- the slave leaves a strobed transfer pending for longer than a programmable number of clock cycles.

The default limit of 1600 cycles is about 16 microseconds at a 100 MHz clock. The block takes no recovery action. It only ends the cycle, and the master decides what to do next. A sticky record keeps the first interconnect fault, with its address and cause, until it is cleared.

Top module: `busguard`

## Requirements
- R1: The address is AW bits wide. Addresses with the top bit clear are split into NSLV equal windows, and window i is the value of the next log2(NSLV) bits below the top bit. While cyc and stb are both high, a mapped address drives only select bit i. All other select bits are low.
- R2: Addresses with the top bit set are unmapped. A strobed cycle to such an address raises m_err in the same cycle. It drives no select line and gives no acknowledge.
- R3: Only the selected slave's acknowledge and error reach the master, and they arrive in the same cycle. Acknowledge and error from slaves that are not selected have no effect.
- R4: A strobed, mapped cycle that gets no acknowledge or error has m_err raised in the cycle after stb has been high for TIMEOUT_CYC clock edges. The error lasts one cycle. The count then restarts from zero.
- R5: The watchdog count returns to zero when stb or cyc is low, or when the cycle ends by acknowledge or error. A later strobe times out only after a full TIMEOUT_CYC count.
- R6: m_ack and m_err are never high together. If the selected slave gives an error, or the watchdog fires, in the same cycle as an acknowledge, only m_err is raised.
- R7: m_ack, m_err and every select line stay low unless both cyc and stb are high.
- R8: At the clock edge of the first unmapped error or watchdog error, the record sets flt_valid. It stores the address and the cause code: 1 for a watchdog timeout, 2 for an unmapped address. Later faults do not change the record while it is valid.
- R9: flt_clr high at an edge empties the record (valid 0, cause 0, address 0). If a fault occurs in the same cycle, that fault is stored instead.
- R10: After synchronous reset, the record is empty and the watchdog count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_adr | input | AW | Master address |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Error to master |
| s_sel | output | NSLV | Per-slave strobe select |
| s_ack | input | NSLV | Per-slave acknowledge |
| s_err | input | NSLV | Per-slave error |
| flt_clr | input | 1 | Empty the fault record |
| flt_valid | output | 1 | Fault record holds an entry |
| flt_cause | output | 2 | Recorded cause (1 timeout, 2 unmapped) |
| flt_adr | output | AW | Recorded faulting address |

## Verification
Three situations are hard to reach from the ports:
- The watchdog expires in exactly the cycle a late acknowledge arrives.
- A clear of the record lands in the same cycle as a new fault.
- A strobe drops for one cycle partway through a count.

The stimulus holds strobe against a silent slave and counts clock edges from the strobe's rise. This lets it place the acknowledge, the gap or the clear on a known cycle relative to the limit. A full sweep of every address, with all acknowledges asserted and then with only the unselected ones asserted, covers the map.

// File: rtl/busguard_pkg.sv
package busguard_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_TIMEOUT  = 2'd1,
        CAUSE_UNMAPPED = 2'd2
    } fault_cause_e;

    typedef struct packed {
        logic         valid;
        fault_cause_e cause;
    } fault_flags_t;

    function automatic int unsigned sel_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned cnt_width(int unsigned lim);
        return $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/bg_addr_decode.sv
module bg_addr_decode
    import busguard_pkg::*;
#(
    parameter int unsigned AW   = 16,
    parameter int unsigned NSLV = 4
) (
    input  logic [AW-1:0]   adr,
    input  logic            req,
    output logic            unmapped,
    output logic [NSLV-1:0] sel
);
    localparam int unsigned SW = sel_width(NSLV);

    logic [SW-1:0] win;
    logic          upper;

    assign upper    = adr[AW-1];
    assign win      = adr[AW-2 -: SW];
    assign unmapped = req & upper;

    for (genvar i = 0; i < NSLV; i++) begin : g_sel
        assign sel[i] = req & ~upper & (win == SW'(i));
    end

endmodule

// File: rtl/bg_watchdog.sv
module bg_watchdog
    import busguard_pkg::*;
#(
    parameter int unsigned LIMIT = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic term,
    output logic expired
);
    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign expired = active && (cnt == LIM);

    always_ff @(posedge clk) begin
        if (rst || !active || term) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes the limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM);

    // R5: an idle bus leaves the count at zero
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));

endmodule

// File: rtl/bg_fault_log.sv
module bg_fault_log
    import busguard_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_unmapped,
    input  logic          evt_timeout,
    input  logic [AW-1:0] adr,
    input  logic          clr,
    output logic          valid,
    output logic [1:0]    cause,
    output logic [AW-1:0] rec_adr
);
    fault_flags_t  flags;
    logic [AW-1:0] adr_q;
    logic          evt;

    assign evt = evt_unmapped | evt_timeout;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '{valid: 1'b0, cause: CAUSE_NONE};
            adr_q <= '0;
        end else if (evt && (clr || !flags.valid)) begin
            flags <= '{valid: 1'b1,
                       cause: (evt_unmapped ? CAUSE_UNMAPPED : CAUSE_TIMEOUT)};
            adr_q <= adr;
        end else if (clr) begin
            flags <= '{valid: 1'b0, cause: CAUSE_NONE};
            adr_q <= '0;
        end
    end

    assign valid   = flags.valid;
    assign cause   = flags.cause;
    assign rec_adr = adr_q;

    // R8: a held record stays put until cleared
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr) |=> (valid && $stable(rec_adr) && $stable(cause)));

    // R9: a clear with no fault empties the record
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !valid);

endmodule

// File: rtl/busguard.sv
module busguard
    import busguard_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned NSLV        = 4,
    parameter int unsigned TIMEOUT_CYC = 1600
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            m_cyc,
    input  logic            m_stb,
    input  logic [AW-1:0]   m_adr,
    output logic            m_ack,
    output logic            m_err,
    output logic [NSLV-1:0] s_sel,
    input  logic [NSLV-1:0] s_ack,
    input  logic [NSLV-1:0] s_err,
    input  logic            flt_clr,
    output logic            flt_valid,
    output logic [1:0]      flt_cause,
    output logic [AW-1:0]   flt_adr
);
    logic req, unmapped, expired, sel_ack, sel_err;

    assign req = m_cyc & m_stb;

    bg_addr_decode #(.AW(AW), .NSLV(NSLV)) u_dec (
        .adr      (m_adr),
        .req      (req),
        .unmapped (unmapped),
        .sel      (s_sel)
    );

    assign sel_ack = |(s_ack & s_sel);
    assign sel_err = |(s_err & s_sel);

    assign m_err = req & (unmapped | expired | sel_err);
    assign m_ack = req & sel_ack & ~m_err;

    bg_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .active  (req),
        .term    (m_ack | m_err),
        .expired (expired)
    );

    bg_fault_log #(.AW(AW)) u_log (
        .clk          (clk),
        .rst          (rst),
        .evt_unmapped (unmapped),
        .evt_timeout  (expired & ~unmapped),
        .adr          (m_adr),
        .clr          (flt_clr),
        .valid        (flt_valid),
        .cause        (flt_cause),
        .rec_adr      (flt_adr)
    );

    // R6: acknowledge and error never together
    p_ack_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(m_ack && m_err));

    // R7: responses only inside a strobed cycle
    p_resp_qual_r7: assert property (@(posedge clk) disable iff (rst)
        (m_ack || m_err || (s_sel != '0)) |-> (m_cyc && m_stb));

    // R1: at most one slave selected
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_sel));

    // R2: upper half errors with no select
    p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && m_stb && m_adr[AW-1]) |-> ((s_sel == '0) && m_err && !m_ack));

endmodule

// File: tb/busguard_tb.sv
module busguard_tb;
    localparam int AW = 6;
    localparam int NSLV = 4;
    localparam int LIM = 5;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_cyc = 1'b0, m_stb = 1'b0;
    logic [AW-1:0] m_adr = '0;
    logic m_ack, m_err;
    logic [NSLV-1:0] s_sel;
    logic [NSLV-1:0] s_ack = '0, s_err = '0;
    logic flt_clr = 1'b0;
    logic flt_valid;
    logic [1:0] flt_cause;
    logic [AW-1:0] flt_adr;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busguard #(.AW(AW), .NSLV(NSLV), .TIMEOUT_CYC(LIM)) u_dut (
        .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_adr(m_adr),
        .m_ack(m_ack), .m_err(m_err), .s_sel(s_sel), .s_ack(s_ack),
        .s_err(s_err), .flt_clr(flt_clr), .flt_valid(flt_valid),
        .flt_cause(flt_cause), .flt_adr(flt_adr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        m_cyc = 0; m_stb = 0; s_ack = '0; s_err = '0; flt_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NSLV-1:0] es;
        @(negedge clk); step(); step();
        rst = 0;
        #1;
        check("R10 reset valid", flt_valid, 0);
        check("R10 reset cause", flt_cause, 0);
        check("R10 reset adr", flt_adr, 0);
        check("R7 idle err", m_err, 0);
        @(negedge clk);

        // R7: strobe without cycle gives nothing
        m_adr = 6'd40; m_stb = 1; m_cyc = 0; s_ack = '1; #1;
        check("R7 no cyc err", m_err, 0);
        check("R7 no cyc ack", m_ack, 0);
        check("R7 no cyc sel", s_sel, 0);
        step(); idle(); step();

        // R1 R2 R3 sweep of every address
        for (int a = 0; a < (1 << AW); a++) begin
            es = (a < 32) ? NSLV'(1 << (a / 8)) : '0;
            m_adr = AW'(a); m_cyc = 1; m_stb = 1; s_ack = '1; s_err = '0; #1;
            check("R1 sel", s_sel, es);
            check("R2 err", m_err, (a >= 32));
            check("R3 ack", m_ack, (a < 32));
            step(); idle(); step();
            if (a < 32) begin
                m_cyc = 1; m_stb = 1; s_ack = ~es; s_err = ~es; #1;
                check("R3 ignore unselected ack", m_ack, 0);
                check("R3 ignore unselected err", m_err, 0);
                step(); idle(); step();
            end
        end
        check("R8 first fault valid", flt_valid, 1);
        check("R8 first fault adr", flt_adr, 32);
        check("R8 first fault cause", flt_cause, 2);

        // R9 clear
        flt_clr = 1; step(); idle(); #1;
        check("R9 clear valid", flt_valid, 0);
        check("R9 clear cause", flt_cause, 0);
        check("R9 clear adr", flt_adr, 0);
        @(negedge clk);

        // R4 timeout on silent slave
        m_adr = 6'd5; m_cyc = 1; m_stb = 1;
        for (int k = 0; k <= LIM + 2; k++) begin
            #1;
            check("R4 timeout timing", m_err, (k == LIM));
            check("R4 no ack", m_ack, 0);
            step();
        end
        idle(); #1;
        check("R8 timeout cause", flt_cause, 1);
        check("R8 timeout adr", flt_adr, 5);
        check("R8 timeout valid", flt_valid, 1);
        flt_clr = 1; step(); idle(); step();

        // R5 gap in strobe restarts count
        m_adr = 6'd9; m_cyc = 1; m_stb = 1;
        for (int k = 0; k < 3; k++) begin #1; check("R5 pre-gap err", m_err, 0); step(); end
        m_stb = 0; step(); m_stb = 1;
        for (int k = 0; k <= LIM; k++) begin
            #1; check("R5 restart timing", m_err, (k == LIM)); step();
        end
        idle(); step();

        // R5 ack just before limit then new strobe
        m_adr = 6'd17; m_cyc = 1; m_stb = 1;
        for (int k = 0; k < LIM; k++) begin
            if (k == LIM - 1) s_ack = 4'b0100;
            #1;
            check("R5 late ack", m_ack, (k == LIM - 1));
            check("R5 late ack err", m_err, 0);
            step();
        end
        s_ack = '0;
        for (int k = 0; k <= LIM; k++) begin
            #1; check("R5 fresh count", m_err, (k == LIM)); step();
        end
        idle(); flt_clr = 1; step(); idle(); step();

        // R6 ack coinciding with expiry, and slave err with ack
        m_adr = 6'd26; m_cyc = 1; m_stb = 1;
        for (int k = 0; k < LIM; k++) step();
        s_ack = 4'b1000; #1;
        check("R6 expiry beats ack err", m_err, 1);
        check("R6 expiry beats ack ack", m_ack, 0);
        step(); idle(); step();
        m_adr = 6'd26; m_cyc = 1; m_stb = 1; s_ack = 4'b1000; s_err = 4'b1000; #1;
        check("R6 slave err with ack err", m_err, 1);
        check("R6 slave err with ack ack", m_ack, 0);
        check("R3 slave err same cycle", m_err, 1);
        step(); idle(); step();

        // R8 record holds (timeout at 26 stored), R9 clear with simultaneous fault
        check("R8 hold adr", flt_adr, 26);
        m_adr = 6'd50; m_cyc = 1; m_stb = 1; flt_clr = 1; step(); idle(); #1;
        check("R9 clear+fault valid", flt_valid, 1);
        check("R9 clear+fault adr", flt_adr, 50);
        check("R9 clear+fault cause", flt_cause, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule